// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory Access Arbiter

This block decides, on every clock, which single word access goes out to a memory built from sixteen independent banks. Word addresses are interleaved on their low-order bits, so neighbouring words live in neighbouring banks. After a bank is touched it stays occupied for four clocks, and no other access may reach it during that time. The arbiter serves two requesters.

The first requester is a strided vector stream. It is described by a start address, a constant word increment, an element count and a write flag. The arbiter walks the stream in element order. It stalls an element whose bank is still occupied, and it pulses a completion flag once the final element has gone out. With unit or odd increments the stream issues one word per clock. Increments of 8 or 16 keep landing on banks that are still occupied, so they run at half or quarter rate.

The second requester is a scalar port that holds its request until it is granted. It is limited to one word every second clock, and it yields to the vector stream whenever both could issue in the same clock. The outputs are the bank number, the row inside the bank, an enable and a write flag, plus grant and stall indications for each requester. The banks themselves are represented only by their occupancy timers.

Top module: `ilv_bank_arb`

## Requirements
- R1: An issued access drives `mem_en` high, `mem_bank` with address bits [3:0] and `mem_row` with address bits [19:4] of the granted word. When nothing issues, `mem_en`, `mem_bank` and `mem_row` are all zero.
- R2: After a bank is accessed in clock t, no access reaches that bank again before clock t+4. An access to it in clock t+4 is allowed.
- R3: A vector start accepted in clock s issues element i at word address (base + i*stride) mod 2^20. The elements go out in increasing i, at most one per clock, and the first may issue in clock s+1.
- R4: When every group of up to 4 consecutive elements falls in distinct banks (any odd stride, or strides 1, 2, 4), a stream of L elements issues in L back-to-back clocks.
- R5: An element whose bank is occupied waits. With stride 8 the stream issues two elements per four clocks, and with stride 16 or 0 it issues one element per four clocks.
- R6: `vec_stall` is high in every clock where a stream is active and nothing from it issues. `sc_stall` is high in every clock where `sc_req` is high and no scalar grant is given.
- R7: After a scalar grant, no scalar grant is given in the following clock.
- R8: When the vector stream can issue in a clock, it takes the slot and the scalar request waits. At most one access issues per clock.
- R9: `vec_done` is high for exactly the one clock after the clock in which the final element issues, and `vec_busy` is low in that clock.
- R10: A start pulse while a stream is active has no effect on the running stream, and a start with length 0 issues nothing and raises no `vec_done`.
- R11: During reset and for the first clocks after it, no grant, stall, done or enable is raised.
- R12: `mem_we` equals the write flag of the requester being served: the flag captured at vector start, or `sc_we` for a scalar access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vec_start | input | 1 | Start a vector stream (taken only when idle and length nonzero) |
| vec_base | input | 20 | Word address of element 0 |
| vec_stride | input | 20 | Word increment between elements, modulo 2^20 |
| vec_len | input | 7 | Element count |
| vec_we | input | 1 | Stream is a write |
| sc_req | input | 1 | Scalar request, held until granted |
| sc_addr | input | 20 | Scalar word address |
| sc_we | input | 1 | Scalar access is a write |
| mem_en | output | 1 | An access issues this clock |
| mem_we | output | 1 | Issued access is a write |
| mem_bank | output | 4 | Target bank |
| mem_row | output | 16 | Word index inside the bank |
| vec_grant | output | 1 | A vector element issues this clock |
| vec_stall | output | 1 | Stream active but held by an occupied bank |
| vec_busy | output | 1 | A stream is in progress |
| vec_done | output | 1 | One-clock pulse after the final element |
| sc_grant | output | 1 | The scalar request issues this clock |
| sc_stall | output | 1 | Scalar request waiting |

## Verification
A vector element and a scalar request can compete for the same issue slot. The bench raises the scalar request in the first clock of a unit-stride stream, with the scalar word in a bank the stream does not use. It then expects the scalar side to stall for exactly as many clocks as the stream issues, and to be granted in the clock right after the final element. The stream timing itself is predicted by a bank-occupancy schedule computed in the bench over a sweep of strides and lengths, and each grant clock and address is compared against that schedule.

// File: rtl/ilv_arb_pkg.sv
package ilv_arb_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_VEC  = 2'd1,
    SRC_SCL  = 2'd2
  } src_e;
endpackage

// File: rtl/ilv_rst_sync.sv
module ilv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer #(
  parameter int BANK_W   = 4,
  parameter int BUSY_CYC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hit_en,
  input  logic [BANK_W-1:0]        hit_bank,
  output logic [(1<<BANK_W)-1:0]   bank_free
);
  localparam int NBANK = 1 << BANK_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYC - 1);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;
    logic             hit_me;

    assign hit_me = hit_en && (hit_bank == BANK_W'(g));

    always_comb begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
      if (hit_me) begin
        cnt_d  = RELOAD;
        cnt_en = 1'b1;
      end else if (cnt_q != '0) begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign bank_free[g] = (cnt_q == '0);
  end
endmodule

// File: rtl/ilv_vec_seq.sv
module ilv_vec_seq #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  len,
  input  logic              we,
  input  logic              advance,
  output logic              active,
  output logic [ADDR_W-1:0] addr,
  output logic              we_o,
  output logic              done
);
  logic              active_q, active_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] step_q, step_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              we_q, we_d;
  logic              done_q, done_d;
  logic              accept;
  logic              final_elem;

  assign accept     = start && !active_q && (len != '0);
  assign final_elem = (left_q == LEN_W'(1));

  always_comb begin
    active_d = active_q;
    addr_d   = addr_q;
    step_d   = step_q;
    left_d   = left_q;
    we_d     = we_q;
    done_d   = 1'b0;
    if (accept) begin
      active_d = 1'b1;
      addr_d   = base;
      step_d   = stride;
      left_d   = len;
      we_d     = we;
    end else if (advance && active_q) begin
      addr_d = addr_q + step_q;
      left_d = left_q - 1'b1;
      if (final_elem) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      step_q   <= '0;
      left_q   <= '0;
      we_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      if (accept || advance) begin
        addr_q <= addr_d;
        left_q <= left_d;
      end
      if (accept) begin
        step_q <= step_d;
        we_q   <= we_d;
      end
    end
  end

  assign active = active_q;
  assign addr   = addr_q;
  assign we_o   = we_q;
  assign done   = done_q;
endmodule

// File: rtl/ilv_bank_arb.sv
module ilv_bank_arb
  import ilv_arb_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BANK_W   = 4,
  parameter int BUSY_CYC = 4,
  parameter int LEN_W    = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vec_start,
  input  logic [ADDR_W-1:0]        vec_base,
  input  logic [ADDR_W-1:0]        vec_stride,
  input  logic [LEN_W-1:0]         vec_len,
  input  logic                     vec_we,
  input  logic                     sc_req,
  input  logic [ADDR_W-1:0]        sc_addr,
  input  logic                     sc_we,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [BANK_W-1:0]        mem_bank,
  output logic [ADDR_W-BANK_W-1:0] mem_row,
  output logic                     vec_grant,
  output logic                     vec_stall,
  output logic                     vec_busy,
  output logic                     vec_done,
  output logic                     sc_grant,
  output logic                     sc_stall
);
  localparam int NBANK = 1 << BANK_W;
  localparam int ROW_W = ADDR_W - BANK_W;

  logic              rst_i_n;
  logic              vec_active;
  logic [ADDR_W-1:0] vec_addr;
  logic              vec_we_q;
  logic [NBANK-1:0]  bank_free;
  logic [BANK_W-1:0] vec_bank;
  logic [BANK_W-1:0] sc_bank;
  logic              sc_gap_q, sc_gap_d;
  logic              run_q;
  src_e              src;

  ilv_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ilv_vec_seq #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) vec_seq_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (vec_start),
    .base    (vec_base),
    .stride  (vec_stride),
    .len     (vec_len),
    .we      (vec_we),
    .advance (vec_grant),
    .active  (vec_active),
    .addr    (vec_addr),
    .we_o    (vec_we_q),
    .done    (vec_done)
  );

  ilv_bank_timer #(
    .BANK_W   (BANK_W),
    .BUSY_CYC (BUSY_CYC)
  ) bank_timer_i (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .hit_en    (mem_en),
    .hit_bank  (mem_bank),
    .bank_free (bank_free)
  );

  assign vec_bank = vec_addr[BANK_W-1:0];
  assign sc_bank  = sc_addr[BANK_W-1:0];

  // vector side wins the slot whenever its bank is free
  assign vec_grant = vec_active && bank_free[vec_bank];
  assign sc_grant  = run_q && sc_req && !sc_gap_q && bank_free[sc_bank] && !vec_grant;
  assign vec_stall = vec_active && !vec_grant;
  assign sc_stall  = run_q && sc_req && !sc_grant;
  assign vec_busy  = vec_active;

  always_comb begin
    if (vec_grant)     src = SRC_VEC;
    else if (sc_grant) src = SRC_SCL;
    else               src = SRC_IDLE;
  end

  always_comb begin
    mem_en   = 1'b0;
    mem_we   = 1'b0;
    mem_bank = '0;
    mem_row  = '0;
    case (src)
      SRC_VEC: begin
        mem_en   = 1'b1;
        mem_we   = vec_we_q;
        mem_bank = vec_bank;
        mem_row  = vec_addr[ADDR_W-1:BANK_W];
      end
      SRC_SCL: begin
        mem_en   = 1'b1;
        mem_we   = sc_we;
        mem_bank = sc_bank;
        mem_row  = sc_addr[ADDR_W-1:BANK_W];
      end
      default: ;
    endcase
  end

  assign sc_gap_d = sc_grant;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sc_gap_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      sc_gap_q <= sc_gap_d;
      run_q    <= 1'b1;
    end
  end

  logic unused_row_w;
  assign unused_row_w = (ROW_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/ilv_bank_arb_chk.sv
module ilv_bank_arb_chk #(
  parameter int BANK_W   = 4,
  parameter int BUSY_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic [BANK_W-1:0] mem_bank,
  input logic              vec_grant,
  input logic              vec_busy,
  input logic              vec_done,
  input logic              sc_req,
  input logic              sc_grant,
  input logic              sc_stall
);
  localparam int NBANK = 1 << BANK_W;
  localparam int AGE_W = $clog2(BUSY_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(BUSY_CYC);
  localparam logic [AGE_W-1:0] AGE_OK  = AGE_W'(BUSY_CYC - 1);

  for (genvar g = 0; g < NBANK; g++) begin : g_age
    logic [AGE_W-1:0] age_q;
    logic             hit;
    assign hit = mem_en && (mem_bank == BANK_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                age_q <= AGE_MAX;
      else if (hit)              age_q <= '0;
      else if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
    end

    // R2
    bank_recycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (age_q >= AGE_OK));
  end

  // R8
  one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_grant && sc_grant));

  // R7
  sc_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_grant |=> !sc_grant);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_done |-> ($past(vec_grant) && !vec_busy));

  // R1
  issue_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_grant || sc_grant) |-> mem_en);

  // R6
  sc_stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_stall |-> (sc_req && !sc_grant));

  // R3
  vec_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_grant |-> vec_busy);
endmodule

bind ilv_bank_arb ilv_bank_arb_chk #(
  .BANK_W   (BANK_W),
  .BUSY_CYC (BUSY_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_en    (mem_en),
  .mem_bank  (mem_bank),
  .vec_grant (vec_grant),
  .vec_busy  (vec_busy),
  .vec_done  (vec_done),
  .sc_req    (sc_req),
  .sc_grant  (sc_grant),
  .sc_stall  (sc_stall)
);

// File: tb/ilv_bank_arb_tb.sv
module ilv_bank_arb_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = CLK_P / 2;
  localparam int MASK  = (1 << 20) - 1;

  logic        clk;
  logic        rst_n;
  logic        vec_start;
  logic [19:0] vec_base;
  logic [19:0] vec_stride;
  logic [6:0]  vec_len;
  logic        vec_we;
  logic        sc_req;
  logic [19:0] sc_addr;
  logic        sc_we;
  logic        mem_en, mem_we;
  logic [3:0]  mem_bank;
  logic [15:0] mem_row;
  logic        vec_grant, vec_stall, vec_busy, vec_done, sc_grant, sc_stall;

  int n_chk = 0;
  int n_bad = 0;

  ilv_bank_arb dut_i (
    .clk(clk), .rst_n(rst_n), .vec_start(vec_start), .vec_base(vec_base),
    .vec_stride(vec_stride), .vec_len(vec_len), .vec_we(vec_we),
    .sc_req(sc_req), .sc_addr(sc_addr), .sc_we(sc_we),
    .mem_en(mem_en), .mem_we(mem_we), .mem_bank(mem_bank), .mem_row(mem_row),
    .vec_grant(vec_grant), .vec_stall(vec_stall), .vec_busy(vec_busy),
    .vec_done(vec_done), .sc_grant(sc_grant), .sc_stall(sc_stall)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one clock: drive at negedge (by caller), then sample just before posedge
  task automatic to_sample();
    #(HALF - 1);
  endtask

  task automatic run_vec(input int base, input int stride, input int len, input bit we);
    int texp[64];
    int aexp[64];
    int last[16];
    int tl, k;
    bit t_ok, a_ok, d_ok, s_ok;
    int t_act, t_exp, a_act, a_exp;
    for (int b = 0; b < 16; b++) last[b] = -100;
    tl = -1;
    for (int i = 0; i < len; i++) begin
      int a, b, t;
      a = (base + i * stride) & MASK;
      b = a & 15;
      t = (tl + 1 > last[b] + 4) ? tl + 1 : last[b] + 4;
      texp[i] = t; aexp[i] = a; last[b] = t; tl = t;
    end
    @(negedge clk);
    vec_base = base[19:0]; vec_stride = stride[19:0]; vec_len = len[6:0];
    vec_we = we; vec_start = 1'b1;
    k = 0; t_ok = 1; a_ok = 1; d_ok = 1; s_ok = 1;
    t_act = 0; t_exp = 0; a_act = 0; a_exp = 0;
    for (int j = 0; j <= tl + 2; j++) begin
      @(negedge clk);
      vec_start = 1'b0;
      to_sample();
      if (vec_grant) begin
        if (k >= len || j != texp[k]) begin
          if (t_ok) begin t_act = j; t_exp = (k < len) ? texp[k] : -1; end
          t_ok = 0;
        end else if ({mem_row, mem_bank} != aexp[k][19:0] || mem_we != we || !mem_en) begin
          if (a_ok) begin a_act = {mem_row, mem_bank}; a_exp = aexp[k]; end
          a_ok = 0;
        end
        k++;
      end else if (j <= tl && !vec_stall) s_ok = 0;
      if (vec_done != (j == tl + 1)) d_ok = 0;
    end
    if (k != len && t_ok) begin t_ok = 0; t_act = k; t_exp = len; end
    // R4 R5 grant clocks follow the bank schedule
    chk(t_ok, "R4/R5", $sformatf("grant clock s=%0d L=%0d", stride, len), t_act, t_exp);
    // R3 R1 R12 element addresses and write flag
    chk(a_ok, "R3", $sformatf("element address s=%0d L=%0d", stride, len), a_act, a_exp);
    // R9 done pulse
    chk(d_ok, "R9", $sformatf("done pulse s=%0d L=%0d", stride, len), d_ok, 1);
    // R6 stall while waiting
    chk(s_ok, "R6", $sformatf("vector stall s=%0d L=%0d", stride, len), s_ok, 1);
    idle(5);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int lens[4];
    int strides[23];
    int gj[4];
    int ng;
    bit ok;
    rst_n = 1'b0; vec_start = 1'b0; vec_base = '0; vec_stride = '0; vec_len = '0;
    vec_we = 1'b0; sc_req = 1'b0; sc_addr = '0; sc_we = 1'b0;
    idle(3);
    to_sample();
    // R11 quiet in reset
    chk(!mem_en && !vec_grant && !sc_grant && !vec_busy && !vec_done && !vec_stall && !sc_stall,
        "R11", "outputs in reset", mem_en, 0);
    @(negedge clk); rst_n = 1'b1;
    sc_req = 1'b1; sc_addr = 20'h00003;
    to_sample();
    // R11 no grant in the first clock after release
    chk(!sc_grant && !mem_en, "R11", "grant right after release", sc_grant, 0);
    @(negedge clk); sc_req = 1'b0;
    idle(6);
    to_sample();
    chk(!mem_en && mem_bank == 0 && mem_row == 0, "R1", "idle outputs zero", mem_en, 0);

    // vector sweep
    lens[0] = 1; lens[1] = 3; lens[2] = 16; lens[3] = 64;
    for (int s = 0; s <= 20; s++) strides[s] = s;
    strides[21] = MASK;          // -1
    strides[22] = MASK - 7;      // -8
    for (int si = 0; si < 23; si++)
      for (int li = 0; li < 4; li++)
        run_vec(37 * si + 5, strides[si], lens[li], (si + li) % 2 == 1);

    // R7 scalar pacing to distinct banks: grants at 0,2,4
    ng = 0; ok = 1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      sc_req = (ng < 3); sc_addr = 20'(16 * j + ng + 1); sc_we = 1'b1;
      to_sample();
      if (sc_grant) begin
        if (ng < 3) gj[ng] = j;
        if (mem_we != 1'b1 || mem_bank != 4'(ng + 1)) ok = 0;
        ng++;
      end else if (sc_req && !sc_stall) ok = 0;
    end
    @(negedge clk); sc_req = 1'b0;
    chk(ng == 3 && gj[0] == 0 && gj[1] == 2 && gj[2] == 4, "R7", "scalar grant spacing", gj[1], 2);
    // R12 scalar write flag, R6 scalar stall
    chk(ok, "R12", "scalar write flag and stall", ok, 1);
    idle(5);

    // R2 scalar to same bank twice: grants at 0 and 4
    ng = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      sc_req = (ng < 2); sc_addr = (ng == 0) ? 20'h00025 : 20'h00035; sc_we = 1'b0;
      to_sample();
      if (sc_grant) begin if (ng < 2) gj[ng] = j; ng++; end
    end
    @(negedge clk); sc_req = 1'b0;
    chk(ng == 2 && gj[0] == 0 && gj[1] == 4, "R2", "same-bank scalar gap", gj[1], 4);
    idle(5);

    // R8 vector and scalar collide in the same clock
    @(negedge clk);
    vec_base = 20'h00010; vec_stride = 20'd1; vec_len = 7'd4; vec_we = 1'b0; vec_start = 1'b1;
    ng = 0; ok = 1; gj[0] = -1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      vec_start = 1'b0;
      if (j == 0) begin sc_req = 1'b1; sc_addr = 20'h00049; sc_we = 1'b1; end
      to_sample();
      if (j < 4 && (!vec_grant || sc_grant || !sc_stall)) ok = 0;
      if (sc_grant) begin
        gj[0] = j;
        if (mem_bank != 4'd9 || mem_row != 16'h0004) ok = 0;
        @(negedge clk); sc_req = 1'b0;
        to_sample();
      end
    end
    chk(ok, "R8", "vector wins shared clock", ok, 1);
    chk(gj[0] == 4, "R8", "scalar grant after stream", gj[0], 4);
    idle(5);

    // R10 start while busy is ignored
    @(negedge clk);
    vec_base = 20'h00100; vec_stride = 20'd1; vec_len = 7'd8; vec_start = 1'b1;
    ng = 0; ok = 1;
    for (int j = 0; j < 14; j++) begin
      @(negedge clk);
      vec_start = (j == 2);
      if (j == 2) begin vec_base = 20'h00555; vec_len = 7'd3; end
      to_sample();
      if (vec_grant) begin
        if (j != ng || {mem_row, mem_bank} != 20'(32'h100 + ng)) ok = 0;
        ng++;
      end
      if (vec_done != (j == 8)) ok = 0;
    end
    chk(ok && ng == 8, "R10", "restart during stream ignored", ng, 8);
    @(negedge clk); vec_start = 1'b0;
    idle(5);

    // R10 zero length start issues nothing
    @(negedge clk);
    vec_base = 20'h00200; vec_len = 7'd0; vec_start = 1'b1;
    ok = 1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      vec_start = 1'b0;
      to_sample();
      if (vec_grant || vec_busy || vec_done || mem_en) ok = 0;
    end
    chk(ok, "R10", "zero length start", ok, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule